// File: doc/BRIEF.md
# Configurable Up/Down Counter with PWM

This block is a general-purpose event and timer counter for a small low-power controller. It counts up or down at the rate of one of eight count sources. Six of the sources are internal clock-enable ticks. The other two are external event pins, which the block synchronises and reduces to their rising edges.

Software can narrow the active width at run time from the full counter to three shorter widths. Counting, wrap points, compare, zero detection and the PWM output all follow the chosen width.

When counting down, the counter reloads from a load register once it has passed zero. When counting up, it returns to the load value after its limited maximum. A compare register drives a one-cycle compare interrupt pulse and sets the duty cycle of a PWM output. A second one-cycle pulse marks the count reaching zero. A flag register outside the block captures both pulses.

Top module: `updown_pwm_counter`

## Requirements
- R1: After reset, all four readable registers read zero and `irq_cmp`, `irq_zero` and `pwm_out` are low.
- R2: The register at address 0 is the control word. Bits [2:0] select the source, bit 3 selects the direction (1 = down), bits [5:4] select the width and bit 6 enables counting. Address 1 holds the load value, address 2 reads the count, and address 3 holds the compare value.
- R3: Counting up, each selected tick adds one. A tick taken at the limited maximum sets the count to the load value, masked to the active width.
- R4: Counting down, each selected tick subtracts one. A tick taken at a count of zero sets the count to the masked load value.
- R5: Width code 0 selects 10 bits, 1 selects 8 bits, 2 selects 6 bits and 3 selects 4 bits. The count read at address 2 never shows bits above the active width.
- R6: Any write to address 2 copies the masked load register into the count, whatever the write data. This load takes priority over a tick in the same cycle.
- R7: Source codes 0 to 5 use `tick_src[code]`. Code 6 uses rising edges of `evt_a` and code 7 uses rising edges of `evt_b`. Each event edge is counted once, however long the level is held, and ticks on unselected sources are ignored.
- R8: `irq_cmp` is high for the cycle after a tick that makes the count equal to the compare value masked to the active width.
- R9: `irq_zero` is high for the cycle after a tick that makes the count zero.
- R10: `pwm_out` is set by a tick that wraps the count to the load value, and is cleared by a tick that produces a compare match. If both happen on the same tick, the clear wins.
- R11: While bit 6 of the control word is clear, the count holds its value and no interrupt pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CW | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CW | Register read data (combinational) |
| tick_src | input | 6 | Internal count-enable ticks, one cycle each |
| evt_a | input | 1 | Asynchronous event pin A |
| evt_b | input | 1 | Asynchronous event pin B |
| irq_cmp | output | 1 | Compare-match interrupt pulse |
| irq_zero | output | 1 | Count-reached-zero interrupt pulse |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions check four properties on every cycle:
- every interrupt pulse follows an accepted tick, and each pulse agrees with the current count and the masked compare value;
- the PWM output only falls together with a compare pulse;
- the readable count never carries bits above the active width;
- the count stays frozen while counting is disabled.

The exact count sequences need the bench's scenarios: wrap and reload values in each direction, narrowing the width in the middle of a count, and event-edge counting through the synchroniser. The same holds for the PWM set, clear and priority order across a full period.

// File: rtl/updown_pwm_counter.sv
module updown_pwm_counter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    rd_addr,
  output logic [CW-1:0] rd_data,
  input  logic [5:0]    tick_src,
  input  logic          evt_a,
  input  logic          evt_b,
  output logic          irq_cmp,
  output logic          irq_zero,
  output logic          pwm_out
);
  localparam int NSRC = 8;
  localparam logic [1:0] A_CTRL = 2'd0, A_LOAD = 2'd1, A_CNT = 2'd2, A_CMP = 2'd3;

  logic [2:0]    src_q;
  logic          dn_q;
  logic [1:0]    wsel_q;
  logic          run_q;
  logic [CW-1:0] load_q, cmp_q, cnt_q;
  logic [2:0]    sync_a, sync_b;
  logic          irq_cmp_q, irq_zero_q, pwm_q;

  logic [CW-1:0]   mask, cnt_lim, load_lim, cmp_lim, nxt;
  logic [NSRC-1:0] srcs;
  logic            step, at_end, load_cmd, hit;

  assign mask     = {CW{1'b1}} >> {wsel_q, 1'b0};
  assign cnt_lim  = cnt_q & mask;
  assign load_lim = load_q & mask;
  assign cmp_lim  = cmp_q & mask;

  assign srcs     = {sync_b[1] & ~sync_b[2], sync_a[1] & ~sync_a[2], tick_src};
  assign load_cmd = wr_en && (wr_addr == A_CNT);
  assign step     = run_q && srcs[src_q] && !load_cmd;

  assign at_end = dn_q ? (cnt_lim == '0) : (cnt_lim == mask);
  assign nxt    = at_end ? load_lim : ((dn_q ? cnt_lim - 1'b1 : cnt_lim + 1'b1) & mask);
  assign hit    = (nxt == cmp_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= {sync_a[1:0], evt_a};
      sync_b <= {sync_b[1:0], evt_b};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dn_q   <= 1'b0;
      wsel_q <= '0;
      run_q  <= 1'b0;
      load_q <= '0;
      cmp_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          src_q  <= wr_data[2:0];
          dn_q   <= wr_data[3];
          wsel_q <= wr_data[5:4];
          run_q  <= wr_data[6];
        end
        A_LOAD:  load_q <= wr_data;
        A_CMP:   cmp_q  <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      irq_cmp_q  <= 1'b0;
      irq_zero_q <= 1'b0;
      pwm_q      <= 1'b0;
    end else begin
      irq_cmp_q  <= step && hit;
      irq_zero_q <= step && (nxt == '0);
      if (load_cmd)
        cnt_q <= load_lim;
      else if (step)
        cnt_q <= nxt;
      if (step && hit)
        pwm_q <= 1'b0;
      else if (step && at_end)
        pwm_q <= 1'b1;
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = CW'({run_q, wsel_q, dn_q, src_q});
      A_LOAD:  rd_data = load_q;
      A_CNT:   rd_data = cnt_lim;
      default: rd_data = cmp_q;
    endcase
  end

  assign irq_cmp  = irq_cmp_q;
  assign irq_zero = irq_zero_q;
  assign pwm_out  = pwm_q;
endmodule

module updown_pwm_counter_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    rd_addr,
  input logic [CW-1:0] rd_data,
  input logic          irq_cmp,
  input logic          irq_zero,
  input logic          pwm_out,
  input logic          step,
  input logic          run_q,
  input logic          load_cmd,
  input logic [CW-1:0] mask,
  input logic [CW-1:0] cnt_lim,
  input logic [CW-1:0] cmp_lim,
  input logic [CW-1:0] cnt_q
);
  // R8
  cmp_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp |-> (cnt_lim == cmp_lim) && $past(step));

  // R9
  zero_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_zero |-> (cnt_lim == '0) && $past(step));

  // R10
  pwm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_out) |-> irq_cmp);

  // R5
  width_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd2) |-> ((rd_data & ~mask) == '0));

  // R11
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load_cmd) |=> $stable(cnt_q) && !irq_cmp && !irq_zero);
endmodule

bind updown_pwm_counter updown_pwm_counter_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
  .irq_cmp(irq_cmp), .irq_zero(irq_zero), .pwm_out(pwm_out),
  .step(step), .run_q(run_q), .load_cmd(load_cmd), .mask(mask),
  .cnt_lim(cnt_lim), .cmp_lim(cmp_lim), .cnt_q(cnt_q)
);

// File: tb/updown_pwm_counter_tb.sv
module updown_pwm_counter_tb;
  localparam int CW = 10;
  localparam time PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic [5:0]    tick_src = '0;
  logic          evt_a = 1'b0, evt_b = 1'b0;
  logic          irq_cmp, irq_zero, pwm_out;

  int checks = 0;
  int errors = 0;

  updown_pwm_counter #(.CW(CW)) u_dut (.*);

  always #(PERIOD/2) clk = ~clk;

  // {addr[1:0], data[9:0], ticks[7:0], expected count[9:0]}
  localparam int NV = 14;
  localparam logic [29:0] VEC [NV] = '{
    {2'd0, 10'h040, 8'd0,  10'h000},  // R2 run, up, 10 bit
    {2'd3, 10'h000, 8'd5,  10'h005},  // R3 R7
    {2'd1, 10'h3FC, 8'd0,  10'h005},
    {2'd0, 10'h070, 8'd0,  10'h005},  // R5 4 bit
    {2'd1, 10'h3FC, 8'd11, 10'h00C},  // R3 wrap to masked load
    {2'd0, 10'h040, 8'd0,  10'h00C},
    {2'd2, 10'h155, 8'd0,  10'h3FC},  // R6 load, data ignored
    {2'd1, 10'h3FC, 8'd4,  10'h3FC},  // R3 full-width wrap
    {2'd0, 10'h048, 8'd3,  10'h3F9},  // R4 down
    {2'd1, 10'h002, 8'd0,  10'h3F9},
    {2'd0, 10'h058, 8'd0,  10'h0F9},  // R5 8 bit
    {2'd0, 10'h068, 8'd58, 10'h002},  // R4 R5 6 bit, reload after zero
    {2'd1, 10'h002, 8'd2,  10'h000},  // R4
    {2'd0, 10'h028, 8'd5,  10'h000}   // R11 run off
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [CW-1:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic noisy_tick();
    @(negedge clk); tick_src = 6'b000001;
    @(negedge clk); tick_src = 6'b111110;
    @(negedge clk); tick_src = 6'b000000;
  endtask

  task automatic one_tick();
    @(negedge clk); tick_src = 6'b000001;
    @(negedge clk); tick_src = 6'b000000;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [CW-1:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 register", v, 0);
    end
    check("R1 irq_cmp", irq_cmp, 0);
    check("R1 irq_zero", irq_zero, 0);
    check("R1 pwm_out", pwm_out, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][29:28], VEC[i][27:18]);
      for (int t = 0; t < int'(VEC[i][17:10]); t++) noisy_tick();
      rd(2'd2, v);
      check($sformatf("R3/R4/R5/R6/R11 vector %0d", i), v, VEC[i][9:0]);
    end
    rd(2'd0, v);
    check("R2 control readback", v, 10'h028);

    // R7 event pins
    wr(2'd1, 10'h000);
    wr(2'd0, 10'h046);
    wr(2'd2, 10'h000);
    evt_a = 1'b1; idle(6);
    rd(2'd2, v); check("R7 evt_a first edge", v, 1);
    idle(6);
    rd(2'd2, v); check("R7 evt_a held level", v, 1);
    evt_a = 1'b0; idle(3); evt_a = 1'b1; idle(6);
    rd(2'd2, v); check("R7 evt_a second edge", v, 2);
    evt_b = 1'b1; idle(6); evt_b = 1'b0; idle(4);
    rd(2'd2, v); check("R7 evt_b unselected", v, 2);
    wr(2'd0, 10'h047);
    evt_b = 1'b1; idle(6);
    rd(2'd2, v); check("R7 evt_b selected", v, 3);
    evt_a = 1'b0; evt_b = 1'b0;

    // R8 R9 R10 compare, zero and PWM, 4-bit up
    wr(2'd1, 10'h000);
    wr(2'd3, 10'h3F3);
    wr(2'd0, 10'h070);
    wr(2'd2, 10'h000);
    one_tick(); one_tick();
    check("R8 no early match", irq_cmp, 0);
    one_tick();
    check("R8 match pulse", irq_cmp, 1);
    idle(1);
    check("R8 single cycle", irq_cmp, 0);
    for (int t = 0; t < 12; t++) one_tick();
    check("R9 no zero at max", irq_zero, 0);
    one_tick();
    check("R9 zero pulse", irq_zero, 1);
    check("R10 set on wrap", pwm_out, 1);
    idle(1);
    check("R9 single cycle", irq_zero, 0);
    one_tick(); one_tick();
    check("R10 high before match", pwm_out, 1);
    one_tick();
    check("R10 cleared on match", pwm_out, 0);
    check("R8 second match", irq_cmp, 1);
    wr(2'd3, 10'h3F0);
    for (int t = 0; t < 12; t++) one_tick();
    one_tick();
    check("R10 clear wins over set", pwm_out, 0);
    check("R8 match at zero", irq_cmp, 1);
    check("R9 zero with match", irq_zero, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule